// File: doc/BRIEF.md
# Shortest-Path Vertex Relaxation Unit

This unit performs the per-vertex step of a single-source shortest-path computation. A vertex job is offered on a start handshake. An update job consumes a stream of pairs of neighbour distance and edge weight, which ends with a flag on its final pair. For each pair the unit forms the sum with saturation and keeps the smallest sum in a running minimum. It then reads the vertex's stored distance through a local read port. When the minimum is strictly smaller, the unit writes it back and announces every outgoing edge of the vertex on an activation stream, so that those neighbours get scheduled again. An initialization job writes the starting distance of one vertex: zero for the source and infinity for every other vertex.

Distances and weights are unsigned. The all-ones code means infinity. A sum that starts from infinity stays infinity. A finite sum that would reach or pass infinity is clamped to the largest finite code. Every job ends with a one-cycle `done` pulse. Walking the graph and fetching the neighbour data are left to the surrounding logic. The activation stream carries edge slot indices (`edge base + k`), and the consumer resolves those indices into neighbour vertices.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a job.
- `ST_INIT`: writes the starting distance.
- `ST_GATHER`: accumulates the stream.
- `ST_READ`: issues the distance read.
- `ST_CMP`: compares, and writes if the distance improves.
- `ST_EMIT`: sends activations.
- `ST_DONE`: pulses `done`.

The transitions are:
- `ST_IDLE`→`ST_INIT` when an init job is accepted, and `ST_IDLE`→`ST_GATHER` when an update job is accepted.
- `ST_INIT`→`ST_DONE`.
- `ST_GATHER`→`ST_READ` when the last pair is accepted. `ST_GATHER` holds while pairs arrive.
- `ST_READ`→`ST_CMP`.
- `ST_CMP`→`ST_EMIT` when the distance improves and the out-degree is non-zero. `ST_CMP`→`ST_DONE` otherwise.
- `ST_EMIT`→`ST_DONE` when the last activation is accepted. `ST_EMIT` holds under backpressure and while activations remain.
- `ST_DONE`→`ST_IDLE`.

Top module: `sssp_relax`

## Requirements
- R1: An init job (`job_init`=1) writes 0 to `job_vid` when `job_is_src`=1 and all-ones (infinity) otherwise. It emits no activation and ends with `done`.
- R2: A neighbour distance equal to infinity gives a sum of infinity for any edge weight.
- R3: A finite neighbour distance whose sum with the weight reaches or exceeds the all-ones code gives the all-ones code minus one.
- R4: The candidate is the minimum of the saturated sums over all pairs of the job, starting from infinity. The stream ends on the pair with `nb_last`=1.
- R5: The stored distance is read with a one-cycle read latency. When the candidate is strictly less than the stored distance, the candidate is written to `job_vid`.
- R6: After such a write, `job_out_deg` activations are emitted, carrying `job_edge_base`+0, +1, … in increasing order. Each one holds valid and value while `act_ready` is low.
- R7: When the candidate is not strictly less than the stored distance, nothing is written and no activation is emitted.
- R8: `job_ready` is high only while the unit is idle. `done` is a single-cycle pulse at the end of every job.
- R9: `nb_ready` is high only while an update job is gathering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| job_valid | input | 1 | Vertex job offered |
| job_ready | output | 1 | Unit idle, job accepted |
| job_init | input | 1 | 1 = initialization job, 0 = update job |
| job_is_src | input | 1 | Init job targets the source vertex |
| job_vid | input | VID_W | Vertex index |
| job_edge_base | input | EDGE_W | First outgoing edge slot |
| job_out_deg | input | DEG_W | Number of outgoing edges |
| nb_valid | input | 1 | Pair valid |
| nb_ready | output | 1 | Pair accepted |
| nb_dist | input | DIST_W | Neighbour distance |
| nb_weight | input | DIST_W | Edge weight |
| nb_last | input | 1 | Final pair of the job |
| rd_en | output | 1 | Distance read strobe |
| rd_addr | output | VID_W | Distance read index |
| rd_data | input | DIST_W | Read data, one cycle after `rd_en` |
| wr_en | output | 1 | Distance write strobe |
| wr_addr | output | VID_W | Distance write index |
| wr_data | output | DIST_W | Distance write value |
| act_valid | output | 1 | Activation valid |
| act_ready | input | 1 | Activation accepted |
| act_edge | output | EDGE_W | Outgoing edge slot to activate |
| done | output | 1 | End-of-job pulse |

## Verification
The bench builds the unit with 4-bit distances, eight vertices, 6-bit edge slots and 3-bit out-degrees. At that size infinity is 15. Every combination of stored distance, neighbour distance and weight fits in a 4096-job sweep, and that sweep covers both saturation cases as well as the equal, improving and worsening comparisons. Multi-pair jobs with out-degrees of 0 to 7 exercise the running minimum and the full activation count. An activation-ready signal that stalls every third cycle exercises the holding behaviour.

// File: rtl/sssp_relax_pkg.sv
package sssp_relax_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_GATHER,
        ST_READ,
        ST_CMP,
        ST_EMIT,
        ST_DONE
    } relax_state_t;

endpackage

// File: rtl/relax_minplus.sv
module relax_minplus #(
    parameter int DIST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [DIST_W-1:0] nb_dist,
    input  logic [DIST_W-1:0] nb_weight,
    output logic [DIST_W-1:0] acc
);
    localparam logic [DIST_W-1:0] INF     = {DIST_W{1'b1}};
    localparam logic [DIST_W:0]   INF_EXT = {1'b0, INF};

    logic [DIST_W:0]   wide_sum;
    logic [DIST_W-1:0] sat_sum;

    // Saturating add: infinity is sticky, a finite overflow clamps below infinity
    always_comb begin
        wide_sum = {1'b0, nb_dist} + {1'b0, nb_weight};
        if (nb_dist == INF)
            sat_sum = INF;
        else if (wide_sum >= INF_EXT)
            sat_sum = INF - 1'b1;
        else
            sat_sum = wide_sum[DIST_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= INF;
        else if (clear)
            acc <= INF;
        else if (en && (sat_sum < acc))
            acc <= sat_sum;
    end
endmodule

// File: rtl/relax_emit.sv
module relax_emit #(
    parameter int EDGE_W = 20,
    parameter int DEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [EDGE_W-1:0] base,
    input  logic [DEG_W-1:0]  deg,
    output logic [EDGE_W-1:0] edge_idx,
    output logic              last
);
    logic [DEG_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end

    assign edge_idx = base + EDGE_W'(cnt);
    assign last     = (cnt == deg - 1'b1);
endmodule

// File: rtl/sssp_relax.sv
module sssp_relax
    import sssp_relax_pkg::*;
#(
    parameter int DIST_W = 16,
    parameter int VID_W  = 10,
    parameter int EDGE_W = 20,
    parameter int DEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_valid,
    output logic              job_ready,
    input  logic              job_init,
    input  logic              job_is_src,
    input  logic [VID_W-1:0]  job_vid,
    input  logic [EDGE_W-1:0] job_edge_base,
    input  logic [DEG_W-1:0]  job_out_deg,
    input  logic              nb_valid,
    output logic              nb_ready,
    input  logic [DIST_W-1:0] nb_dist,
    input  logic [DIST_W-1:0] nb_weight,
    input  logic              nb_last,
    output logic              rd_en,
    output logic [VID_W-1:0]  rd_addr,
    input  logic [DIST_W-1:0] rd_data,
    output logic              wr_en,
    output logic [VID_W-1:0]  wr_addr,
    output logic [DIST_W-1:0] wr_data,
    output logic              act_valid,
    input  logic              act_ready,
    output logic [EDGE_W-1:0] act_edge,
    output logic              done
);
    localparam logic [DIST_W-1:0] INF = {DIST_W{1'b1}};

    relax_state_t      state, nxt;
    logic [VID_W-1:0]  vid_q;
    logic              src_q;
    logic [EDGE_W-1:0] base_q;
    logic [DEG_W-1:0]  deg_q;
    logic [DIST_W-1:0] cand;
    logic              job_fire, nb_fire, improve, emit_last;

    assign job_fire = job_valid && job_ready;
    assign nb_fire  = nb_valid && nb_ready;
    assign improve  = cand < rd_data;

    relax_minplus #(.DIST_W(DIST_W)) u_minplus (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (job_fire),
        .en        (nb_fire),
        .nb_dist   (nb_dist),
        .nb_weight (nb_weight),
        .acc       (cand)
    );

    relax_emit #(.EDGE_W(EDGE_W), .DEG_W(DEG_W)) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_CMP),
        .adv      (act_valid && act_ready),
        .base     (base_q),
        .deg      (deg_q),
        .edge_idx (act_edge),
        .last     (emit_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Job fields captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_q  <= '0;
            src_q  <= 1'b0;
            base_q <= '0;
            deg_q  <= '0;
        end else if (job_fire) begin
            vid_q  <= job_vid;
            src_q  <= job_is_src;
            base_q <= job_edge_base;
            deg_q  <= job_out_deg;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (job_fire) nxt = job_init ? ST_INIT : ST_GATHER;
            ST_INIT:   nxt = ST_DONE;
            ST_GATHER: if (nb_fire && nb_last) nxt = ST_READ;
            ST_READ:   nxt = ST_CMP;
            ST_CMP:    nxt = (improve && (deg_q != '0)) ? ST_EMIT : ST_DONE;
            ST_EMIT:   if (act_ready && emit_last) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        job_ready = 1'b0;
        nb_ready  = 1'b0;
        rd_en     = 1'b0;
        wr_en     = 1'b0;
        wr_data   = cand;
        act_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   job_ready = 1'b1;
            ST_INIT: begin
                wr_en   = 1'b1;
                wr_data = src_q ? '0 : INF;
            end
            ST_GATHER: nb_ready  = 1'b1;
            ST_READ:   rd_en     = 1'b1;
            ST_CMP:    wr_en     = improve;
            ST_EMIT:   act_valid = 1'b1;
            ST_DONE:   done      = 1'b1;
            default:   job_ready = 1'b0;
        endcase
    end

    assign rd_addr = vid_q;
    assign wr_addr = vid_q;
endmodule

// File: rtl/sssp_relax_checker.sv
module sssp_relax_checker #(
    parameter int EDGE_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              job_ready,
    input logic              nb_ready,
    input logic              wr_en,
    input logic              act_valid,
    input logic              act_ready,
    input logic [EDGE_W-1:0] act_edge,
    input logic              done
);
    // R6: a stalled activation keeps valid and value
    p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && !act_ready |=> act_valid && $stable(act_edge));

    // R6: activations only start right after an improving write
    p_emit_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_valid) |-> $past(wr_en));

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8 / R9: idle and gather never overlap, and done excludes streaming
    p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(job_ready && nb_ready));

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !act_valid && !nb_ready && !job_ready);
endmodule

bind sssp_relax sssp_relax_checker #(.EDGE_W(EDGE_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .job_ready (job_ready),
    .nb_ready  (nb_ready),
    .wr_en     (wr_en),
    .act_valid (act_valid),
    .act_ready (act_ready),
    .act_edge  (act_edge),
    .done      (done)
);

// File: tb/sssp_relax_bench.sv
`timescale 1ns/1ps
module sssp_relax_bench;
    localparam int DW = 4, VW = 3, EW = 6, GW = 3;
    localparam int INF = 15;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          job_valid = 0, job_init = 0, job_is_src = 0, job_ready;
    logic [VW-1:0] job_vid = '0;
    logic [EW-1:0] job_edge_base = '0;
    logic [GW-1:0] job_out_deg = '0;
    logic          nb_valid = 0, nb_last = 0, nb_ready;
    logic [DW-1:0] nb_dist = '0, nb_weight = '0;
    logic          rd_en, wr_en, act_valid, done;
    logic [VW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          act_ready = 1'b1;
    logic [EW-1:0] act_edge;

    sssp_relax #(.DIST_W(DW), .VID_W(VW), .EDGE_W(EW), .DEG_W(GW)) u_sssp_relax (
        .clk(clk), .rst_n(rst_n),
        .job_valid(job_valid), .job_ready(job_ready), .job_init(job_init),
        .job_is_src(job_is_src), .job_vid(job_vid), .job_edge_base(job_edge_base),
        .job_out_deg(job_out_deg),
        .nb_valid(nb_valid), .nb_ready(nb_ready), .nb_dist(nb_dist),
        .nb_weight(nb_weight), .nb_last(nb_last),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .act_valid(act_valid), .act_ready(act_ready), .act_edge(act_edge),
        .done(done)
    );

    // Bench-owned distance store, one-cycle read latency
    logic [DW-1:0] mem [8];
    logic          tb_we = 0;
    logic [VW-1:0] tb_addr = '0;
    logic [DW-1:0] tb_data = '0;
    always @(posedge clk) begin
        if (tb_we) mem[tb_addr] <= tb_data;
        else if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end

    // Activation ready stalls every third cycle
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        act_ready <= (cyc % 3) != 0;
    end

    // Activation monitor
    int act_seen = 0, act_bad = 0, seen0 = 0;
    logic [EW-1:0] exp_base = '0;
    always @(posedge clk) begin
        if (act_valid && act_ready) begin
            if (act_edge != exp_base + EW'(act_seen - seen0)) act_bad++;
            act_seen++;
        end
    end

    int vectors = 0, miscomp = 0;
    int pd [8];
    int pw [8];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_sum(input int d, input int w);
        if (d == INF) return INF;
        if (d + w >= INF) return INF - 1;
        return d + w;
    endfunction

    task automatic preload(input int vid, input int val);
        @(negedge clk);
        tb_we = 1; tb_addr = VW'(vid); tb_data = DW'(val);
        @(negedge clk);
        tb_we = 0;
    endtask

    task automatic wait_done(input string req);
        int wlen = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        wlen = done;
        chk(done == 1'b0, req, wlen, 0);  // single-cycle pulse
    endtask

    task automatic run_init(input int vid, input bit src);
        seen0 = act_seen;
        job_valid = 1; job_init = 1; job_is_src = src; job_vid = VW'(vid);
        while (!job_ready) @(negedge clk);
        @(negedge clk);
        job_valid = 0; job_init = 0;
        wait_done("R8");
        chk(int'(mem[vid]) == (src ? 0 : INF), "R1", mem[vid], src ? 0 : INF);
        chk(act_seen == seen0, "R1", act_seen - seen0, 0);
    endtask

    task automatic run_upd(input int vid, input int stored, input int n,
                           input int base, input int deg, input string tag);
        int cand = INF;
        int expd, expa;
        bit better;
        for (int i = 0; i < n; i++) begin
            int s = sat_sum(pd[i], pw[i]);
            if (s < cand) cand = s;
        end
        better = cand < stored;
        expd = better ? cand : stored;
        expa = better ? deg : 0;
        preload(vid, stored);
        seen0 = act_seen; exp_base = EW'(base);
        job_valid = 1; job_vid = VW'(vid);
        job_edge_base = EW'(base); job_out_deg = GW'(deg);
        while (!job_ready) @(negedge clk);
        @(negedge clk);
        job_valid = 0;
        for (int i = 0; i < n; i++) begin
            nb_valid = 1; nb_dist = DW'(pd[i]); nb_weight = DW'(pw[i]);
            nb_last = (i == n - 1);
            while (!nb_ready) @(negedge clk);
            @(negedge clk);
        end
        nb_valid = 0; nb_last = 0;
        begin
            int bad0 = act_bad;
            wait_done("R8");
            chk(int'(mem[vid]) == expd, tag, mem[vid], expd);
            chk(act_seen - seen0 == expa, better ? "R6" : "R7", act_seen - seen0, expa);
            chk(act_bad == bad0, "R6", act_bad - bad0, 0);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lcg = 7;
        repeat (3) @(negedge clk);
        // Reset state
        chk(job_ready == 1'b1, "R8", job_ready, 1);
        chk(done == 1'b0, "R8", done, 0);
        chk(nb_ready == 1'b0, "R9", nb_ready, 0);
        chk(act_valid == 1'b0, "R7", act_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk(nb_ready == 1'b0, "R9", nb_ready, 0);

        // R1: init mode over all vertices, source at 3
        for (int v = 0; v < 8; v++) run_init(v, v == 3);

        // Exhaustive single-pair sweep: R2 R3 R5 R7
        for (int s = 0; s < 16; s++)
            for (int d = 0; d < 16; d++)
                for (int w = 0; w < 16; w++) begin
                    string tag;
                    pd[0] = d; pw[0] = w;
                    if (d == INF) tag = "R2";
                    else if (d + w >= INF) tag = "R3";
                    else if (d + w < s) tag = "R5";
                    else tag = "R7";
                    run_upd((s + d) % 8, s, 1, (d * 4 + w) % 64, 2, tag);
                end

        // R4: multi-pair streams, out-degree 0..7
        for (int k = 0; k < 300; k++) begin
            int n;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            n = 1 + (lcg >> 8) % 6;
            for (int i = 0; i < n; i++) begin
                lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
                pd[i] = (lcg >> 4) % 16;
                pw[i] = (lcg >> 12) % 16;
            end
            run_upd(k % 8, (lcg >> 20) % 16, n, (lcg >> 3) % 64, k % 8, "R4");
        end

        // R5 boundary: candidate equal to stored gives no write
        pd[0] = 5; pw[0] = 3;
        run_upd(2, 8, 1, 10, 4, "R7");
        pd[0] = 5; pw[0] = 2;
        run_upd(2, 8, 1, 60, 7, "R5");  // edge slots wrap past 63
        finish_run();
    end
endmodule